// File: doc/BRIEF.md
# Comparator Status Latch and Interrupt Select

This block is a single 8-bit control and status register that serves two analog comparator columns. It brings each comparator output into the system clock domain and shows it as a read-only status bit. By default that bit is captured on each rising edge of the column phase-2 clock. When the column's latch-disable input is high, the bit tracks the comparator output continuously instead.

Each column also has one writable select bit. The select bit chooses what drives that column's interrupt request line. With select low, the line follows the column's status bit. With select high, the line gives a single-cycle pulse each time phase-2 falls. Phase-2 and the comparator outputs are asynchronous to the system clock, so each passes through a two-flop synchronizer before any edge detection or sampling.

Top module: `cmp_stat_ctl`

## Requirements
- R1: After reset, the register reads 8'h00 and both interrupt lines are low.
- R2: In the read value, the status of column i is at bit 4+i and the select bit of column i is at bit i. Bits 7, 6, 3 and 2 always read 0.
- R3: A write with the write strobe high updates the select bits from write-data bits 1:0, and the new value reads back after the next clock edge. Writing 1 to bits 7:2 changes no readable bit.
- R4: With latch-disable low, a column's status bit changes only when the synchronized phase-2 rises. It takes the synchronized comparator value three clock edges after phase-2 rises at the input, and it holds while phase-2 stays steady.
- R5: With latch-disable high, a column's status bit equals the comparator input delayed by two clock edges, whatever phase-2 does.
- R6: With select 0, a column's interrupt line equals its status bit.
- R7: With select 1, a column's interrupt line is high for exactly one cycle, starting two clock edges after phase-2 falls at the input. Comparator changes and phase-2 rises leave it low.
- R8: The two columns are independent. One column's latch-disable or select setting does not change the other column's status or interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data: status bits at 5:4, select bits at 1:0 |
| cmp_in | input | 2 | Raw comparator output of each column |
| phi2_in | input | 1 | Phase-2 column clock, asynchronous |
| latch_dis | input | 2 | Per-column latch disable (1 = transparent status) |
| irq | output | 2 | Per-column interrupt request |

## Verification
The assertions assume three things about the inputs. Phase-2 stays at each level for at least two system clock cycles, so that no edge is lost in the synchronizer. The latch-disable and write inputs are already synchronous to the system clock. Comparator inputs are steady enough to settle through two flops. The directed stimulus changes every input only a couple of nanoseconds after a rising clock edge. It holds phase-2 at each level for three or more cycles and waits out the synchronizer delay before it samples any result.

// File: rtl/cmp_stat_pkg.sv
package cmp_stat_pkg;
    localparam int unsigned NUM_COLS  = 2;
    localparam int unsigned REG_W     = 8;
    localparam int unsigned STAT_LSB  = 4;
    localparam int unsigned SEL_LSB   = 0;
    localparam int unsigned SYNC_DEPTH = 2;
endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
    parameter int unsigned W      = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] stg;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.stg[0] = din;
        for (int k = 1; k < STAGES; k++) begin
            st_d.stg[k] = st_q.stg[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.stg[STAGES-1];
endmodule

// File: rtl/cmp_edge.sv
module cmp_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ph_in,
    output logic rise,
    output logic fall
);
    typedef struct packed {
        logic prev;
    } edge_st_t;

    edge_st_t st_d, st_q;
    logic     ph_s;

    cmp_sync #(.W(1), .STAGES(STAGES)) u_ph_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (ph_in),
        .dout (ph_s)
    );

    always_comb begin
        st_d      = st_q;
        st_d.prev = ph_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise = ph_s & ~st_q.prev;
    assign fall = ~ph_s & st_q.prev;

    // R7
    fall_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);
endmodule

// File: rtl/cmp_col.sv
module cmp_col (
    input  logic clk,
    input  logic rst_n,
    input  logic cmp_s,
    input  logic ldis,
    input  logic rise,
    input  logic fall,
    input  logic sel,
    output logic stat_o,
    output logic irq_o
);
    typedef struct packed {
        logic stat;
    } col_st_t;

    col_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rise) st_d.stat = cmp_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_o = ldis ? cmp_s : st_q.stat;
    assign irq_o  = sel ? fall : stat_o;

    // R4
    stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ldis && !rise) |=> (ldis || $stable(stat_o)));

    // R7
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && irq_o) |=> (!sel || !irq_o));
endmodule

// File: rtl/cmp_stat_ctl.sv
module cmp_stat_ctl
    import cmp_stat_pkg::*;
#(
    parameter int unsigned N_COL   = NUM_COLS,
    parameter int unsigned RW      = REG_W,
    parameter int unsigned ST_LSB  = STAT_LSB,
    parameter int unsigned SL_LSB  = SEL_LSB,
    parameter int unsigned SYNC_N  = SYNC_DEPTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [RW-1:0]    reg_wdata,
    output logic [RW-1:0]    reg_rdata,
    input  logic [N_COL-1:0] cmp_in,
    input  logic             phi2_in,
    input  logic [N_COL-1:0] latch_dis,
    output logic [N_COL-1:0] irq
);
    localparam logic [RW-1:0] ONES      = '1;
    localparam logic [RW-1:0] COL_MASK  = RW'((1 << N_COL) - 1);
    localparam logic [RW-1:0] USED_MASK = (COL_MASK << ST_LSB) | (COL_MASK << SL_LSB);
    localparam logic [RW-1:0] RSVD_MASK = ONES & ~USED_MASK;

    typedef struct packed {
        logic [N_COL-1:0] sel;
    } top_st_t;

    top_st_t          st_d, st_q;
    logic [N_COL-1:0] cmp_s;
    logic [N_COL-1:0] stat;
    logic             ph_rise, ph_fall;

    cmp_sync #(.W(N_COL), .STAGES(SYNC_N)) u_cmp_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (cmp_in),
        .dout (cmp_s)
    );

    cmp_edge #(.STAGES(SYNC_N)) u_ph_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .ph_in(phi2_in),
        .rise (ph_rise),
        .fall (ph_fall)
    );

    for (genvar c = 0; c < N_COL; c++) begin : g_col
        cmp_col u_col (
            .clk   (clk),
            .rst_n (rst_n),
            .cmp_s (cmp_s[c]),
            .ldis  (latch_dis[c]),
            .rise  (ph_rise),
            .fall  (ph_fall),
            .sel   (st_q.sel[c]),
            .stat_o(stat[c]),
            .irq_o (irq[c])
        );
    end

    always_comb begin
        st_d = st_q;
        if (reg_wr) st_d.sel = reg_wdata[SL_LSB +: N_COL];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        reg_rdata[ST_LSB +: N_COL] = stat;
        reg_rdata[SL_LSB +: N_COL] = st_q.sel;
    end

    // R2
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata & RSVD_MASK) == '0);

    // R3
    sel_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> reg_rdata[SL_LSB +: N_COL] == $past(reg_wdata[SL_LSB +: N_COL]));
endmodule

// File: tb/tb_cmp_stat_ctl.sv
module tb_cmp_stat_ctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [1:0] cmp_in = '0;
    logic       phi2_in = 1'b0;
    logic [1:0] latch_dis = '0;
    logic [1:0] irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cmp_stat_ctl dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_wr   (reg_wr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .cmp_in   (cmp_in),
        .phi2_in  (phi2_in),
        .latch_dis(latch_dis),
        .irq      (irq)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] v);
        reg_wr = 1'b1;
        reg_wdata = v;
        step(1);
        reg_wr = 1'b0;
        reg_wdata = '0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step(3);
        rst_n = 1'b1;
        step(1);
        check("R1 rdata", reg_rdata, 8'h00);
        check("R1 irq", {6'b0, irq}, 8'h00);
    endtask

    task automatic t_write();
        wr(8'hFF);
        check("R3 R2 write all ones", reg_rdata, 8'h03);
        wr(8'h02);
        check("R3 sel col1 only", reg_rdata, 8'h02);
        wr(8'hFC);
        check("R3 reserved ignored", reg_rdata, 8'h00);
    endtask

    task automatic t_latched();
        latch_dis = 2'b00;
        cmp_in = 2'b01;
        step(4);
        check("R4 no phi2 rise holds", reg_rdata, 8'h00);
        phi2_in = 1'b1;
        step(2);
        check("R4 not yet latched", reg_rdata, 8'h00);
        step(1);
        check("R4 latched col0", reg_rdata, 8'h10);
        cmp_in = 2'b10;
        step(4);
        check("R4 steady phi2 holds", reg_rdata, 8'h10);
        check("R6 irq follows status", {6'b0, irq}, 8'h01);
        phi2_in = 1'b0;
        step(3);
        phi2_in = 1'b1;
        step(3);
        check("R4 R8 latched col1", reg_rdata, 8'h20);
        check("R6 irq follows status col1", {6'b0, irq}, 8'h02);
    endtask

    task automatic t_transparent();
        cmp_in = 2'b11;
        latch_dis = 2'b01;
        step(1);
        check("R5 one edge not through", reg_rdata, 8'h20);
        step(1);
        check("R5 follows after two edges", reg_rdata, 8'h30);
        cmp_in = 2'b00;
        step(1);
        check("R5 delay held", reg_rdata, 8'h30);
        step(1);
        check("R5 R8 col0 follows col1 latched", reg_rdata, 8'h20);
        latch_dis = 2'b00;
        step(1);
        check("R4 back to latched value", reg_rdata, 8'h20);
    endtask

    task automatic t_fall_irq();
        wr(8'h01);
        phi2_in = 1'b0;
        step(1);
        check("R7 R8 before pulse", {6'b0, irq}, 8'h02);
        step(1);
        check("R7 pulse", {6'b0, irq}, 8'h03);
        step(1);
        check("R7 pulse one cycle", {6'b0, irq}, 8'h02);
        cmp_in = 2'b01;
        step(4);
        check("R7 comparator ignored", {6'b0, irq}, 8'h02);
        phi2_in = 1'b1;
        step(3);
        check("R4 latch after rise", reg_rdata, 8'h11);
        check("R7 rise gives no pulse", {6'b0, irq}, 8'h00);
        wr(8'h03);
        phi2_in = 1'b0;
        step(2);
        check("R7 R8 both pulse", {6'b0, irq}, 8'h03);
        step(1);
        check("R7 both end", {6'b0, irq}, 8'h00);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_write();
        t_latched();
        t_transparent();
        t_fall_irq();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule